// File: doc/BRIEF.md
# Address-Range Memory Protection Filter

This block sits in front of a memory and decides, for every transaction, whether it may proceed. It holds a small table of rules. Each rule names an address window in 1 MiB pages, an inclusive range of master IDs, the set of ports it applies to, the security states it covers, and a verdict. A transaction that matches no rule takes the verdict held for its port in a per-port default register.

Software programs the table indirectly through four staging registers and a select register. It first fills the address, ID and data staging registers. It then writes the select register with a rule number and the commit bit, which copies the staging registers into that rule. Writing the select register with the load bit copies the chosen rule back into the staging registers, where software can read it. Transactions are presented as an address, a master ID, a port number and a secure flag. The verdict appears one clock later.

Top module: `mem_guard`

## Requirements
- R1: After reset every rule is invalid, the default register reads 0 and every staging register reads 0, so every transaction is accepted.
- R2: Register offsets are 0 for select, 1 for address staging, 2 for ID staging, 3 for data staging and 4 for default. Staging registers read back what was written, zero-extended. A select write with bit 6 set and rule number n in bits 4:0 loads rule n into the staging registers.
- R3: A select write with bit 5 set and rule number n in bits 4:0 copies the staging registers into rule n. Address staging holds the start page in bits 11:0 and the inclusive end page in bits 23:12. Both pages compare against transaction address bits 31:20.
- R4: ID staging holds the inclusive low ID bound in bits 11:0 and the inclusive high bound in bits 23:12. The transaction ID must lie within these bounds.
- R5: Data staging bits 12:3 form a port mask. A rule applies only when the mask bit indexed by the transaction port is set.
- R6: Data staging bit 0 lets a rule match secure transactions and bit 1 lets it match non-secure ones. Bit 2 marks the rule valid.
- R7: Data staging bit 13 is the result of a matching rule: 0 accepts and 1 rejects.
- R8: When several rules match, the lowest-numbered one decides.
- R9: When no rule matches, bit p of the default register decides for port p: 0 accepts and 1 rejects. The default register reads back its 10 bits.
- R10: verdict_valid is high exactly one cycle after txn_valid is sampled high. verdict_reject is low whenever verdict_valid is low.
- R11: Committing all-zero staging registers leaves the rule invalid, so it no longer matches.
- R12: A commit naming a rule number of 20 or above changes no rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| txn_valid | input | 1 | Transaction present |
| txn_addr | input | 32 | Transaction byte address |
| txn_id | input | 12 | Master ID |
| txn_port | input | 4 | Port number |
| txn_secure | input | 1 | 1 = secure transaction |
| verdict_valid | output | 1 | Verdict present |
| verdict_reject | output | 1 | 1 = reject, 0 = accept |

## Verification
Transactions are placed exactly on, just inside and just outside each bound: the first and last byte of the end page, and IDs one below the low bound and one above the high bound. This separates inclusive comparisons from exclusive ones and shows which address bits are compared. Port and security variations around a single rule show that the mask bit and the security bits gate the match independently. Overlapping rules with opposite results are committed and then cleared one by one. Each step then shows which rule has priority, that clearing a rule really removes it, and that the per-port default decides once nothing matches. Out-of-range commits and read-back loads are checked through the register port.

// File: rtl/mem_guard.sv
module mem_guard #(
  parameter int NUM_RULES = 20,
  parameter int NUM_PORTS = 10,
  parameter int PAGE_W    = 12,
  parameter int ID_W      = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_valid,
  input  logic        reg_write,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        txn_valid,
  input  logic [31:0] txn_addr,
  input  logic [11:0] txn_id,
  input  logic [3:0]  txn_port,
  input  logic        txn_secure,
  output logic        verdict_valid,
  output logic        verdict_reject
);
  localparam int AW    = 2 * PAGE_W;
  localparam int IW    = 2 * ID_W;
  localparam int DW    = 4 + NUM_PORTS;
  localparam int SEL_W = 5;

  logic [AW-1:0]    rule_a [NUM_RULES];
  logic [IW-1:0]    rule_i [NUM_RULES];
  logic [DW-1:0]    rule_d [NUM_RULES];
  logic [AW-1:0]    stg_a, stg_i_unused_w;
  logic [IW-1:0]    stg_i;
  logic [DW-1:0]    stg_d;
  logic [NUM_PORTS-1:0] dflt;
  logic [SEL_W-1:0] sel;

  wire wr       = reg_valid && reg_write;
  wire [SEL_W-1:0] wsel = reg_wdata[SEL_W-1:0];
  wire sel_ok   = wsel < SEL_W'(NUM_RULES);
  wire do_commit = wr && reg_addr == 3'd0 && reg_wdata[5] && sel_ok;
  wire do_load   = wr && reg_addr == 3'd0 && reg_wdata[6] && !reg_wdata[5] && sel_ok;

  assign stg_i_unused_w = '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_a <= '0; stg_i <= '0; stg_d <= '0; dflt <= '0; sel <= '0;
      for (int r = 0; r < NUM_RULES; r++) begin
        rule_a[r] <= '0; rule_i[r] <= '0; rule_d[r] <= '0;
      end
    end else begin
      if (wr) begin
        case (reg_addr)
          3'd0: sel   <= wsel;
          3'd1: stg_a <= reg_wdata[AW-1:0];
          3'd2: stg_i <= reg_wdata[IW-1:0];
          3'd3: stg_d <= reg_wdata[DW-1:0];
          3'd4: dflt  <= reg_wdata[NUM_PORTS-1:0];
          default: ;
        endcase
      end
      if (do_commit) begin
        rule_a[wsel] <= stg_a; rule_i[wsel] <= stg_i; rule_d[wsel] <= stg_d;
      end
      if (do_load) begin
        stg_a <= rule_a[wsel]; stg_i <= rule_i[wsel]; stg_d <= rule_d[wsel];
      end
    end
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = 32'(sel);
      3'd1:    reg_rdata = 32'(stg_a);
      3'd2:    reg_rdata = 32'(stg_i);
      3'd3:    reg_rdata = 32'(stg_d);
      3'd4:    reg_rdata = 32'(dflt);
      default: reg_rdata = '0;
    endcase
  end

  wire [PAGE_W-1:0] page = txn_addr[31:32-PAGE_W];
  wire port_ok = txn_port < 4'(NUM_PORTS);
  logic rej_c;

  always_comb begin
    rej_c = port_ok ? dflt[txn_port] : 1'b1;
    for (int r = NUM_RULES - 1; r >= 0; r--) begin
      if (rule_d[r][2] && port_ok && rule_d[r][3 + txn_port]
          && (txn_secure ? rule_d[r][0] : rule_d[r][1])
          && page >= rule_a[r][PAGE_W-1:0] && page <= rule_a[r][AW-1:PAGE_W]
          && txn_id >= rule_i[r][ID_W-1:0] && txn_id <= rule_i[r][IW-1:ID_W])
        rej_c = rule_d[r][3 + NUM_PORTS];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      verdict_valid  <= 1'b0;
      verdict_reject <= 1'b0;
    end else begin
      verdict_valid  <= txn_valid;
      verdict_reject <= txn_valid && rej_c;
    end
  end
endmodule

// File: rtl/mem_guard_chk.sv
module mem_guard_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_valid,
  input logic        reg_write,
  input logic [2:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic [31:0] reg_rdata,
  input logic        txn_valid,
  input logic        verdict_valid,
  input logic        verdict_reject
);
  p_verdict_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |=> verdict_valid);
  p_verdict_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !txn_valid |=> !verdict_valid);
  p_reject_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !verdict_valid |-> !verdict_reject);
  p_default_readback_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && reg_write && reg_addr == 3'd4) |=>
      (reg_addr != 3'd4 || reg_rdata == {22'd0, $past(reg_wdata[9:0])}));
  p_stage_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && reg_write && reg_addr == 3'd1) |=>
      (reg_addr != 3'd1 || reg_rdata == {8'd0, $past(reg_wdata[23:0])}));
endmodule

bind mem_guard mem_guard_chk i_mem_guard_chk (
  .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .txn_valid(txn_valid), .verdict_valid(verdict_valid),
  .verdict_reject(verdict_reject));

// File: tb/test_mem_guard.sv
module test_mem_guard;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic reg_valid = 0, reg_write = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic txn_valid = 0, txn_secure = 0;
  logic [31:0] txn_addr = 0;
  logic [11:0] txn_id = 0;
  logic [3:0] txn_port = 0;
  logic verdict_valid, verdict_reject;

  int checks = 0, fails = 0;
  bit exp_q[$];
  string tag_q[$];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_guard i_mem_guard (.*);

  always @(negedge clk) begin
    if (rst_n && verdict_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R10 unexpected verdict act=%0b exp=none", verdict_reject);
      end else begin
        automatic bit e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (verdict_reject !== e) begin
          fails++;
          $display("FAIL %s reject act=%0b exp=%0b", t, verdict_reject, e);
        end
      end
    end
  end

  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    reg_valid = 1; reg_write = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_valid = 0; reg_write = 0;
  endtask

  task automatic rreg(input logic [2:0] a, input logic [31:0] exp, input string t);
    reg_addr = a; reg_write = 0; #1;
    checks++;
    if (reg_rdata !== exp) begin
      fails++;
      $display("FAIL %s reg%0d act=%h exp=%h", t, a, reg_rdata, exp);
    end
    @(negedge clk);
  endtask

  task automatic txn(input logic [31:0] a, input logic [11:0] id, input logic [3:0] p,
                     input logic sec, input bit exp, input string t);
    exp_q.push_back(exp); tag_q.push_back(t);
    txn_valid = 1; txn_addr = a; txn_id = id; txn_port = p; txn_secure = sec;
    @(negedge clk);
    txn_valid = 0;
  endtask

  task automatic commit(input int n, input logic [31:0] a, input logic [31:0] i,
                        input logic [31:0] d);
    wreg(3'd1, a); wreg(3'd2, i); wreg(3'd3, d); wreg(3'd0, 32'(n) | 32'h20);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 5; a++) rreg(3'(a), 32'h0, "R1");
    txn(32'h1234_5678, 12'h055, 4'd7, 1'b1, 1'b0, "R1");
    txn(32'hFFFF_FFFF, 12'hFFF, 4'd0, 1'b0, 1'b0, "R1");
    // R9 defaults
    wreg(3'd4, 32'h3FF);
    rreg(3'd4, 32'h3FF, "R9");
    txn(32'h5000_0000, 12'h001, 4'd0, 1'b1, 1'b1, "R9");
    wreg(3'd4, 32'h004);
    txn(32'h5000_0000, 12'h001, 4'd2, 1'b1, 1'b1, "R9");
    txn(32'h5000_0000, 12'h001, 4'd3, 1'b1, 1'b0, "R9");
    wreg(3'd4, 32'h0);
    // rule 3: pages 0x010..0x01F, IDs 0x010..0x020, ports 2 and 5, secure only, reject
    commit(3, 32'h01F010, 32'h020010, 32'h2125);
    txn(32'h0100_0000, 12'h010, 4'd2, 1'b1, 1'b1, "R3");
    txn(32'h01FF_FFFF, 12'h020, 4'd5, 1'b1, 1'b1, "R3");
    txn(32'h0200_0000, 12'h015, 4'd2, 1'b1, 1'b0, "R3");
    txn(32'h00FF_FFFF, 12'h015, 4'd2, 1'b1, 1'b0, "R3");
    txn(32'h0150_0000, 12'h00F, 4'd2, 1'b1, 1'b0, "R4");
    txn(32'h0150_0000, 12'h021, 4'd2, 1'b1, 1'b0, "R4");
    txn(32'h0150_0000, 12'h018, 4'd3, 1'b1, 1'b0, "R5");
    txn(32'h0150_0000, 12'h018, 4'd5, 1'b0, 1'b0, "R6");
    // back-to-back verdicts, R7 result bit
    exp_q.push_back(1'b1); tag_q.push_back("R7");
    exp_q.push_back(1'b0); tag_q.push_back("R10");
    txn_valid = 1; txn_addr = 32'h0180_0000; txn_id = 12'h012; txn_port = 4'd5; txn_secure = 1;
    @(negedge clk);
    txn_port = 4'd4;
    @(negedge clk);
    txn_valid = 0;
    // R2 read-back through load
    wreg(3'd1, 32'h0); wreg(3'd2, 32'h0); wreg(3'd3, 32'h0);
    rreg(3'd1, 32'h0, "R2");
    wreg(3'd0, 32'h43);
    rreg(3'd0, 32'h3, "R2");
    rreg(3'd1, 32'h01F010, "R2");
    rreg(3'd2, 32'h020010, "R2");
    rreg(3'd3, 32'h2125, "R2");
    // R12 commit to rule 20 ignored
    commit(20, 32'hFFF000, 32'hFFF000, 32'h3FFF);
    txn(32'h5000_0000, 12'h001, 4'd0, 1'b1, 1'b0, "R12");
    wreg(3'd0, 32'h54);
    rreg(3'd3, 32'h3FFF, "R12");
    // R8 priority: rule 1 accepts all, rule 0 rejects all
    commit(1, 32'hFFF000, 32'hFFF000, 32'h1FFF);
    txn(32'h0150_0000, 12'h018, 4'd2, 1'b1, 1'b0, "R8");
    commit(0, 32'hFFF000, 32'hFFF000, 32'h3FFF);
    txn(32'h0150_0000, 12'h018, 4'd2, 1'b1, 1'b1, "R8");
    txn(32'h9000_0000, 12'h700, 4'd9, 1'b0, 1'b1, "R8");
    // R11 clearing
    commit(0, 32'h0, 32'h0, 32'h0);
    txn(32'h0150_0000, 12'h018, 4'd2, 1'b1, 1'b0, "R11");
    commit(1, 32'h0, 32'h0, 32'h0);
    txn(32'h0150_0000, 12'h018, 4'd2, 1'b1, 1'b1, "R11");
    txn(32'h9000_0000, 12'h700, 4'd9, 1'b0, 1'b0, "R11");
    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R10 missing verdicts act=%0d exp=0", exp_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule